// File: doc/BRIEF.md
# Dual Half-Bank Cartridge Memory Mapper

This block is a bank controller that sits between an 8-bit CPU with a 16-bit address bus and a cartridge holding a large ROM and a battery-backed SRAM. Both memories are reached through pairs of independently banked 4 KiB windows. The switchable ROM area at 0x4000–0x7FFF has a lower and an upper window. The external RAM area at 0xA000–0xBFFF has a lower half at 0xA000 and an upper half at 0xB000. Software moves each window by writing a bank number into control registers. These registers are decoded on 1 KiB slices of the low, write-only half of the address map.

The CPU side is a plain synchronous bus: address, write data, write strobe, read strobe and a combinational read-data return. The memory side gets a physical ROM byte address, a physical SRAM byte address, SRAM write data and an SRAM write enable. The read data of both memory arrays comes back into the block, which selects what the CPU sees. SRAM reads and writes are guarded by an enable latch, so a cartridge that has not been unlocked returns 0xFF and ignores stores. Bank numbers that point past the installed memory wrap, because both memory sizes are powers of two.

Top module: `halfbank_mapper`

## Requirements
- R1: After reset the SRAM enable latch is clear, the lower ROM window selects bank 2, the upper ROM window bank 3, the lower SRAM half bank 0 and the upper SRAM half bank 1.
- R2: A write whose address bits [15:10] equal 6'h00 sets the SRAM enable latch when the data is 8'h0A and clears it when the data is 8'h00. Any other data value leaves the latch unchanged.
- R3: A write with address bits [15:10] equal to 6'h01 loads all 8 data bits as the lower SRAM half bank. Bits [15:10] equal to 6'h02 load the upper SRAM half bank.
- R4: A write with address bits [15:10] equal to 6'h08 or 6'h09 loads all 8 data bits as the lower ROM window bank. Bits [15:10] equal to 6'h0C or 6'h0D load the upper ROM window bank.
- R5: For addresses 0x4000–0x5FFF, rom_addr is (lower ROM bank × 4096 + address[11:0]) mod ROM_BYTES. For 0x6000–0x7FFF the upper ROM bank is used in the same way.
- R6: For addresses 0xA000–0xAFFF, sram_addr is (lower SRAM bank × 4096 + address[11:0]) mod SRAM_BYTES. For 0xB000–0xBFFF the upper SRAM bank is used. A bank past the installed size therefore wraps.
- R7: sram_we is high exactly when the write strobe is high, the address lies in 0xA000–0xBFFF and the enable latch is set. sram_wdata carries the CPU write data.
- R8: While the read strobe is high in 0xA000–0xBFFF, cpu_rdata is 8'hFF if the enable latch is clear and sram_rdata if it is set.
- R9: While the read strobe is high in 0x4000–0x7FFF, cpu_rdata is rom_rdata. It is 8'hFF at every other address outside the SRAM area, and whenever the read strobe is low.
- R10: A write to any other control slice (bits [15:10] below 6'h20 and not 6'h00, 6'h01, 6'h02, 6'h08, 6'h09, 6'h0C or 6'h0D) changes neither a bank register nor the enable latch.
- R11: A control write takes effect on the first access after the clock edge that ends the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_rdata | input | 8 | Data from the ROM array |
| sram_addr | output | SRAM_AW | Physical SRAM byte address |
| sram_wdata | output | 8 | Data to the SRAM array |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 8 | Data from the SRAM array |

## Verification
Bank selection is tried in three ways: values inside the installed size, values that exceed it (including 8'hFF), and the second address slice of each two-slice ROM register. These separate correct slice decoding from correct wrapping. Data written through the lower SRAM half with a wrapped bank is read back through the upper half with the bank it aliases to. This shows that both halves reach one shared physical array and do not address separate storage. The enable latch is driven with the lock key, the unlock key and a foreign value, and both stores and loads are tried in each state. Writes to unused control slices are followed by readback of every window mapping and of the lock state, so that a stray decode becomes visible at the ports.

// File: rtl/hbm_pkg.sv
`timescale 1ns/1ps
package hbm_pkg;

  localparam int WIN_OFF_W = 12;
  localparam int BANK_W    = 8;
  localparam int WIDE_W    = BANK_W + WIN_OFF_W;

  typedef logic [BANK_W-1:0]    bank_t;
  typedef logic [WIN_OFF_W-1:0] woff_t;

  localparam logic [7:0] UNLOCK_KEY = 8'h0A;
  localparam logic [7:0] LOCK_KEY   = 8'h00;

  localparam bank_t RST_ROM_LO  = 8'd2;
  localparam bank_t RST_ROM_HI  = 8'd3;
  localparam bank_t RST_SRAM_LO = 8'd0;
  localparam bank_t RST_SRAM_HI = 8'd1;

  typedef enum logic [2:0] {
    CS_LOCK, CS_SRAM_LO, CS_SRAM_HI, CS_ROM_LO, CS_ROM_HI, CS_NONE
  } ctl_slice_e;

  typedef enum logic [2:0] {
    RG_ROM_LO, RG_ROM_HI, RG_SRAM_LO, RG_SRAM_HI, RG_OTHER
  } region_e;

  typedef struct packed {
    logic  unlocked;
    bank_t rom_lo;
    bank_t rom_hi;
    bank_t sram_lo;
    bank_t sram_hi;
  } map_state_t;

  function automatic ctl_slice_e decode_slice(input logic [5:0] s);
    case (s)
      6'h00:        return CS_LOCK;
      6'h01:        return CS_SRAM_LO;
      6'h02:        return CS_SRAM_HI;
      6'h08, 6'h09: return CS_ROM_LO;
      6'h0C, 6'h0D: return CS_ROM_HI;
      default:      return CS_NONE;
    endcase
  endfunction

  function automatic region_e region_of(input logic [15:0] a);
    if (a[15:13] == 3'b010)      return RG_ROM_LO;
    else if (a[15:13] == 3'b011) return RG_ROM_HI;
    else if (a[15:12] == 4'hA)   return RG_SRAM_LO;
    else if (a[15:12] == 4'hB)   return RG_SRAM_HI;
    else                         return RG_OTHER;
  endfunction

endpackage

// File: rtl/hbm_ctrl_regs.sv
`timescale 1ns/1ps
module hbm_ctrl_regs
  import hbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output map_state_t  st
);

  ctl_slice_e kind;
  assign kind = decode_slice(addr[15:10]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st.unlocked <= 1'b0;
      st.rom_lo   <= RST_ROM_LO;
      st.rom_hi   <= RST_ROM_HI;
      st.sram_lo  <= RST_SRAM_LO;
      st.sram_hi  <= RST_SRAM_HI;
    end else if (wr) begin
      case (kind)
        CS_LOCK: begin
          if (wdata == UNLOCK_KEY)    st.unlocked <= 1'b1;
          else if (wdata == LOCK_KEY) st.unlocked <= 1'b0;
        end
        CS_SRAM_LO: st.sram_lo <= wdata;
        CS_SRAM_HI: st.sram_hi <= wdata;
        CS_ROM_LO:  st.rom_lo  <= wdata;
        CS_ROM_HI:  st.rom_hi  <= wdata;
        default: ;
      endcase
    end
  end

  // R1: defaults after reset
  assert_reset_defaults_R1: assert property (@(posedge clk)
    rst |=> (!st.unlocked && st.rom_lo == 8'd2 && st.rom_hi == 8'd3 &&
             st.sram_lo == 8'd0 && st.sram_hi == 8'd1));

  assert_unlock_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:10] == 6'h00 && wdata == 8'h0A) |=> st.unlocked);

  assert_lock_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:10] == 6'h00 && wdata == 8'h00) |=> !st.unlocked);

  assert_key_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:10] == 6'h00 && wdata != 8'h00 && wdata != 8'h0A)
    |=> $stable(st.unlocked));

  assert_sram_lo_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:10] == 6'h01) |=> st.sram_lo == $past(wdata));

  assert_sram_hi_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:10] == 6'h02) |=> st.sram_hi == $past(wdata));

  assert_rom_lo_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:11] == 5'b00100) |=> st.rom_lo == $past(wdata));

  assert_rom_hi_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:11] == 5'b00110) |=> st.rom_hi == $past(wdata));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr || addr[15] || (addr[15:10] != 6'h00 && addr[15:10] != 6'h01 &&
      addr[15:10] != 6'h02 && addr[15:11] != 5'b00100 && addr[15:11] != 5'b00110))
    |=> $stable(st));

endmodule

// File: rtl/hbm_xlate.sv
`timescale 1ns/1ps
module hbm_xlate
  import hbm_pkg::*;
#(
  parameter int PHYS_AW = 17
) (
  input  bank_t               bank,
  input  woff_t               off,
  output logic [PHYS_AW-1:0]  phys
);

  logic [WIDE_W-1:0] wide;
  assign wide = {bank, off};

  // A power-of-two memory keeps the low PHYS_AW bits: this is the wrap.
  generate
    if (PHYS_AW >= WIDE_W) begin : g_extend
      assign phys = {{(PHYS_AW-WIDE_W){1'b0}}, wide};
    end else begin : g_wrap
      assign phys = wide[PHYS_AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/hbm_rdata_mux.sv
`timescale 1ns/1ps
module hbm_rdata_mux
  import hbm_pkg::*;
(
  input  logic    rd,
  input  region_e region,
  input  logic    unlocked,
  input  logic [7:0] rom_rdata,
  input  logic [7:0] sram_rdata,
  output logic [7:0] rdata
);

  always_comb begin
    rdata = 8'hFF;
    if (rd) begin
      case (region)
        RG_ROM_LO, RG_ROM_HI:   rdata = rom_rdata;
        RG_SRAM_LO, RG_SRAM_HI: rdata = unlocked ? sram_rdata : 8'hFF;
        default:                rdata = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/halfbank_mapper.sv
`timescale 1ns/1ps
module halfbank_mapper
  import hbm_pkg::*;
#(
  parameter int ROM_BYTES  = 131072,
  parameter int SRAM_BYTES = 32768,
  localparam int ROM_AW    = $clog2(ROM_BYTES),
  localparam int SRAM_AW   = $clog2(SRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  output logic [7:0]         cpu_rdata,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [7:0]         rom_rdata,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               sram_we,
  input  logic [7:0]         sram_rdata
);

  map_state_t st;
  region_e    region;
  woff_t      off;
  bank_t      rom_bank;
  bank_t      sram_bank;
  logic       in_sram;

  assign region    = region_of(cpu_addr);
  assign off       = cpu_addr[WIN_OFF_W-1:0];
  assign rom_bank  = (region == RG_ROM_HI)  ? st.rom_hi  : st.rom_lo;
  assign sram_bank = (region == RG_SRAM_HI) ? st.sram_hi : st.sram_lo;
  assign in_sram   = (region == RG_SRAM_LO) || (region == RG_SRAM_HI);

  hbm_ctrl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (cpu_wr),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .st    (st)
  );

  hbm_xlate #(.PHYS_AW(ROM_AW)) u_rom_xlate (
    .bank (rom_bank),
    .off  (off),
    .phys (rom_addr)
  );

  hbm_xlate #(.PHYS_AW(SRAM_AW)) u_sram_xlate (
    .bank (sram_bank),
    .off  (off),
    .phys (sram_addr)
  );

  hbm_rdata_mux u_mux (
    .rd         (cpu_rd),
    .region     (region),
    .unlocked   (st.unlocked),
    .rom_rdata  (rom_rdata),
    .sram_rdata (sram_rdata),
    .rdata      (cpu_rdata)
  );

  assign sram_we    = cpu_wr && in_sram && st.unlocked;
  assign sram_wdata = cpu_wdata;

  assert_rom_map_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b01) |->
      (32'(rom_addr) == ((32'(cpu_addr[13] ? st.rom_hi : st.rom_lo) * 4096
                          + 32'(cpu_addr[11:0])) % ROM_BYTES)));

  assert_sram_map_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:13] == 3'b101) |->
      (32'(sram_addr) == ((32'(cpu_addr[12] ? st.sram_hi : st.sram_lo) * 4096
                           + 32'(cpu_addr[11:0])) % SRAM_BYTES)));

  assert_we_guard_R7: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (cpu_wr && st.unlocked && cpu_addr[15:13] == 3'b101));

  assert_we_fire_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && st.unlocked && cpu_addr[15:13] == 3'b101) |-> sram_we);

  assert_locked_ff_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && !st.unlocked) |-> cpu_rdata == 8'hFF);

  assert_rom_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:14] == 2'b01) |-> cpu_rdata == rom_rdata);

  assert_idle_ff_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |-> cpu_rdata == 8'hFF);

endmodule

// File: tb/halfbank_mapper_tb_top.sv
`timescale 1ns/1ps
module halfbank_mapper_tb_top;

  localparam int ROM_BYTES  = 131072;
  localparam int SRAM_BYTES = 32768;
  localparam int ROM_AW     = $clog2(ROM_BYTES);
  localparam int SRAM_AW    = $clog2(SRAM_BYTES);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [15:0]        cpu_addr = 16'h0000;
  logic [7:0]         cpu_wdata = 8'h00;
  logic               cpu_wr = 1'b0;
  logic               cpu_rd = 1'b0;
  logic [7:0]         cpu_rdata;
  logic [ROM_AW-1:0]  rom_addr;
  logic [7:0]         rom_rdata = 8'h00;
  logic [SRAM_AW-1:0] sram_addr;
  logic [7:0]         sram_wdata;
  logic               sram_we;
  logic [7:0]         sram_rdata = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] sram_mem [int unsigned];

  always #2 clk = ~clk;

  halfbank_mapper #(.ROM_BYTES(ROM_BYTES), .SRAM_BYTES(SRAM_BYTES)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_we(sram_we), .sram_rdata(sram_rdata)
  );

  function automatic logic [7:0] rom_byte(input int unsigned a);
    return 8'(a) ^ 8'(a >> 12) ^ 8'h5C;
  endfunction

  function automatic int unsigned exp_rom(input int unsigned bank, input int unsigned a);
    return (bank * 4096 + (a & 32'hFFF)) % ROM_BYTES;
  endfunction

  function automatic int unsigned exp_sram(input int unsigned bank, input int unsigned a);
    return (bank * 4096 + (a & 32'hFFF)) % SRAM_BYTES;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, output logic we_seen);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    we_seen = sram_we;
    if (sram_we) sram_mem[32'(sram_addr)] = sram_wdata;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic we;
    cpu_write(a, d, we);
  endtask

  // Drives a read, refreshes the memory models from the mapped addresses,
  // then samples cpu_rdata and the physical addresses.
  task automatic cpu_read(input logic [15:0] a, input logic rd_en,
                          output logic [7:0] data, output int unsigned ra,
                          output int unsigned sa);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd_en; cpu_wr = 1'b0;
    #0.5;
    rom_rdata  = rom_byte(32'(rom_addr));
    sram_rdata = sram_mem.exists(32'(sram_addr)) ? sram_mem[32'(sram_addr)] : 8'h00;
    #0.5;
    data = cpu_rdata; ra = 32'(rom_addr); sa = 32'(sram_addr);
  endtask

  task automatic chk_rom(input string req, input logic [15:0] a, input int unsigned bank);
    logic [7:0] d; int unsigned ra, sa;
    cpu_read(a, 1'b1, d, ra, sa);
    chk(req, $sformatf("rom_addr @%h", a), ra, exp_rom(bank, a));
    chk(req, $sformatf("rom data @%h", a), 32'(d), 32'(rom_byte(exp_rom(bank, a))));
  endtask

  task automatic chk_sram_map(input string req, input logic [15:0] a, input int unsigned bank);
    logic [7:0] d; int unsigned ra, sa;
    cpu_read(a, 1'b1, d, ra, sa);
    chk(req, $sformatf("sram_addr @%h", a), sa, exp_sram(bank, a));
  endtask

  task automatic chk_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d; int unsigned ra, sa;
    cpu_read(a, 1'b1, d, ra, sa);
    chk(req, $sformatf("cpu_rdata @%h", a), 32'(d), 32'(exp));
  endtask

  task automatic t_reset;
    chk_rom("R1", 16'h4123, 2);
    chk_rom("R1", 16'h6456, 3);
    chk_sram_map("R1", 16'hA010, 0);
    chk_sram_map("R1", 16'hB010, 1);
    chk_read("R1", 16'hA010, 8'hFF);
  endtask

  task automatic t_unlock;
    logic we;
    cpu_write(16'hA005, 8'h77, we);
    chk("R7", "sram_we while locked", 32'(we), 0);
    wr(16'h0000, 8'h0A);
    cpu_write(16'hA005, 8'h55, we);
    chk("R7", "sram_we while unlocked", 32'(we), 1);
    chk_read("R8", 16'hA005, 8'h55);
    wr(16'h03FF, 8'h5A);
    chk_read("R2", 16'hA005, 8'h55);
    wr(16'h0100, 8'h00);
    chk_read("R2", 16'hA005, 8'hFF);
    cpu_write(16'hA005, 8'h99, we);
    chk("R7", "sram_we after relock", 32'(we), 0);
    wr(16'h0000, 8'h0A);
    chk_read("R7", 16'hA005, 8'h55);
  endtask

  task automatic t_sram_banks;
    logic [7:0] d; int unsigned ra, sa;
    wr(16'h0400, 8'd5);
    chk_sram_map("R3", 16'hA123, 5);
    chk_sram_map("R11", 16'hAFFF, 5);
    wr(16'h0800, 8'd6);
    chk_sram_map("R3", 16'hB123, 6);
    wr(16'hA321, 8'hC1);
    wr(16'hB321, 8'hC2);
    chk_read("R3", 16'hA321, 8'hC1);
    chk_read("R3", 16'hB321, 8'hC2);
    wr(16'h07FF, 8'd9);
    chk_sram_map("R6", 16'hA200, 9);
    wr(16'hA200, 8'h3C);
    wr(16'h0BFF, 8'd1);
    chk_read("R6", 16'hB200, 8'h3C);
    wr(16'h0800, 8'hFF);
    cpu_read(16'hBABC, 1'b1, d, ra, sa);
    chk("R6", "sram_addr bank FF", sa, 32'h7ABC);
  endtask

  task automatic t_rom_banks;
    wr(16'h2000, 8'd7);
    chk_rom("R4", 16'h4ABC, 7);
    chk_rom("R5", 16'h5FFF, 7);
    wr(16'h27FF, 8'h11);
    chk_rom("R4", 16'h4001, 8'h11);
    wr(16'h3000, 8'h20);
    chk_rom("R5", 16'h6777, 0);
    wr(16'h37FF, 8'h25);
    chk_rom("R5", 16'h7FF0, 8'h25);
    chk_rom("R11", 16'h4001, 8'h11);
  endtask

  task automatic t_undecoded;
    logic [7:0] d; int unsigned ra, sa;
    wr(16'h0400, 8'd4);
    wr(16'h0800, 8'd2);
    wr(16'h0C00, 8'h00);
    wr(16'h1000, 8'h00);
    wr(16'h1C00, 8'h00);
    wr(16'h2800, 8'h1F);
    wr(16'h2C00, 8'h1F);
    wr(16'h3800, 8'h1F);
    wr(16'h3C00, 8'h1F);
    wr(16'h7C00, 8'h00);
    wr(16'h5000, 8'h1F);
    chk_rom("R10", 16'h4ABC, 8'h11);
    chk_rom("R10", 16'h6ABC, 8'h25);
    chk_sram_map("R10", 16'hA0F0, 4);
    chk_sram_map("R10", 16'hB0F0, 2);
    cpu_read(16'hA005, 1'b1, d, ra, sa);
    chk("R10", "unlock kept", 32'(d), 32'(sram_mem.exists(sa) ? sram_mem[sa] : 8'h00));
    chk("R10", "unlock kept (not FF path)", 32'(d != 8'hFF || (sram_mem.exists(sa) && sram_mem[sa] == 8'hFF)), 1);
  endtask

  task automatic t_other_reads;
    logic [7:0] d; int unsigned ra, sa;
    chk_read("R9", 16'hC000, 8'hFF);
    chk_read("R9", 16'h8000, 8'hFF);
    chk_read("R9", 16'h1234, 8'hFF);
    cpu_read(16'h4ABC, 1'b0, d, ra, sa);
    chk("R9", "rdata with rd low", 32'(d), 32'hFF);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    sram_mem[32'h5] = 8'h00;
    sram_mem.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_unlock();
    t_sram_banks();
    t_rom_banks();
    t_undecoded();
    t_other_reads();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule